// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address used inside a synchronous burst memory, one address per enabled clock. A load cycle with the device selected captures a full external address. That address becomes the first access of a burst. Each following advance cycle steps the two least significant address bits through a four-beat pattern. The rest of the address stays at the loaded value.

Two beat patterns are available, and a static mode input picks one:
- **Linear:** the low bits count up modulo four from the start value.
- **Interleaved:** the start low bits are XORed with the beat number.

A load cycle taken while the device is deselected ends the burst. Advance cycles after that produce no valid access until a new selected load. A stall input freezes the whole block for the cycles in which it is high. Each registered output reflects the access started by the most recent enabled clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the block. After that edge acc_valid is 0 and acc_addr is 0.
- R2: A load cycle (stall=0, adv=0, sel=1) captures ext_addr. After the edge acc_addr equals ext_addr and acc_valid is 1.
- R3: With order_ilv=0 (linear), the k-th advance after a load gives acc_addr[1:0] = (start[1:0] + k) mod 4.
- R4: With order_ilv=1 (interleaved), the k-th advance after a load gives acc_addr[1:0] = start[1:0] XOR (k mod 4).
- R5: The fourth advance after a load returns acc_addr to the start address. acc_addr[ADDR_W-1:2] never changes on an advance cycle.
- R6: ext_addr has no effect on an advance cycle (stall=0, adv=1).
- R7: A load cycle with sel=0 ends the burst. After the edge acc_valid is 0 and acc_addr keeps its previous value. Advance cycles that follow keep acc_valid at 0 and acc_addr unchanged.
- R8: A stall cycle (stall=1) changes nothing: acc_addr, acc_valid and the burst position all hold. The next advance continues the sequence from where it stopped.
- R9: sel has no effect on an advance cycle. A live burst keeps advancing whatever the value of sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | 1: the edge is ignored entirely |
| adv | input | 1 | 1: advance the burst; 0: load or deselect |
| sel | input | 1 | Device selected (chip enables already qualified) |
| order_ilv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| ext_addr | input | ADDR_W | External word address |
| acc_addr | output | ADDR_W | Address of the current access |
| acc_valid | output | 1 | Current cycle is a valid access |

## Verification
Errors in the internal state show at the ports quickly:
- **Beat counter:** a wrong value appears at the next advance as wrong low bits of acc_addr.
- **Start register:** a wrong value shows the same way, one advance later at most.
- **Valid flag:** a wrong value shows in acc_valid at once.
- **Stall handling:** a fault shows as an output change during the stall, or as a skipped or repeated beat on the first advance after it.

The bench compares both outputs with a behavioural model after every clock. Every such fault is therefore reported within one or two cycles of the stimulus that exposes it.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_e;

endpackage

// File: rtl/burst_order.sv
module burst_order
    import burst_addr_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat,
    input  logic              mode,
    output logic [BEAT_W-1:0] low
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    assign lin_low = start_low + beat;

    // Interleaved order: each bit is flipped independently by the beat count.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = start_low[b] ^ beat[b];
    end

    always_comb begin
        if (order_e'(mode) == ORD_INTERLEAVED) begin
            low = ilv_low;
        end else begin
            low = lin_low;
        end
    end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              adv,
    input  logic              sel,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [BEAT_W-1:0] low_next,
    output logic [BEAT_W-1:0] start_low,
    output logic [BEAT_W-1:0] beat_next,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_valid
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic              live;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] start;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    ctrl_t st_d;
    ctrl_t st_q;

    assign beat_next = st_q.beat + 1'b1;
    assign start_low = st_q.start;

    always_comb begin
        st_d = st_q;
        if (!stall) begin
            if (!adv) begin
                st_d.beat = '0;
                if (sel) begin
                    st_d.live  = 1'b1;
                    st_d.start = ext_addr[BEAT_W-1:0];
                    st_d.addr  = ext_addr;
                end else begin
                    st_d.live = 1'b0;
                end
            end else if (st_q.live) begin
                st_d.beat = beat_next;
                st_d.addr = {st_q.addr[ADDR_W-1 -: UPPER_W], low_next};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_addr  = st_q.addr;
    assign acc_valid = st_q.live;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              adv,
    input  logic              sel,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_valid
);

    logic [BEAT_W-1:0] start_low;
    logic [BEAT_W-1:0] beat_next;
    logic [BEAT_W-1:0] low_next;

    burst_order #(
        .BEAT_W(BEAT_W)
    ) i_order (
        .start_low(start_low),
        .beat     (beat_next),
        .mode     (order_ilv),
        .low      (low_next)
    );

    burst_ctrl #(
        .ADDR_W(ADDR_W),
        .BEAT_W(BEAT_W)
    ) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .stall    (stall),
        .adv      (adv),
        .sel      (sel),
        .ext_addr (ext_addr),
        .low_next (low_next),
        .start_low(start_low),
        .beat_next(beat_next),
        .acc_addr (acc_addr),
        .acc_valid(acc_valid)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              adv,
    input logic              sel,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_valid
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!acc_valid && acc_addr == '0));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stall) && !$past(adv) && $past(sel))
        |-> (acc_valid && acc_addr == $past(ext_addr)));

    // R5
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stall) && $past(adv))
        |-> $stable(acc_addr[ADDR_W-1:BEAT_W]));

    // R7
    deselect_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stall) && !$past(adv) && !$past(sel))
        |-> (!acc_valid && $stable(acc_addr)));

    // R7
    dead_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stall) && $past(adv) && !$past(acc_valid))
        |-> (!acc_valid && $stable(acc_addr)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(stall))
        |-> ($stable(acc_addr) && $stable(acc_valid)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W(ADDR_W),
    .BEAT_W(BEAT_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .adv      (adv),
    .sel      (sel),
    .ext_addr (ext_addr),
    .acc_addr (acc_addr),
    .acc_valid(acc_valid)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stall = 1'b0;
    logic          adv = 1'b0;
    logic          sel = 1'b0;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] acc_addr;
    logic          acc_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int m_start = 0;
    int m_addr = 0;
    int m_beat = 0;
    bit m_valid = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) i_burst_addr_gen (
        .clk      (clk),
        .rst      (rst),
        .stall    (stall),
        .adv      (adv),
        .sel      (sel),
        .order_ilv(order_ilv),
        .ext_addr (ext_addr),
        .acc_addr (acc_addr),
        .acc_valid(acc_valid)
    );

    task automatic model_edge(input bit r, input bit s, input bit a, input bit c, input int ea);
        int low;
        if (r) begin
            m_valid = 0; m_addr = 0; m_beat = 0; m_start = 0;
        end else if (!s) begin
            if (!a) begin
                m_beat = 0;
                if (c) begin
                    m_valid = 1; m_start = ea; m_addr = ea;
                end else begin
                    m_valid = 0;
                end
            end else if (m_valid) begin
                m_beat = (m_beat + 1) % 4;
                if (order_ilv) low = (m_start % 4) ^ m_beat;
                else           low = ((m_start % 4) + m_beat) % 4;
                m_addr = (m_start / 4) * 4 + low;
            end
        end
    endtask

    task automatic compare(input string req);
        checks++;
        if (int'(acc_addr) != m_addr) begin
            errors++;
            $display("FAIL %s acc_addr actual=%h expected=%h", req, acc_addr, m_addr[AW-1:0]);
        end
        checks++;
        if (acc_valid != m_valid) begin
            errors++;
            $display("FAIL %s acc_valid actual=%0d expected=%0d", req, acc_valid, m_valid);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit r, input bit s, input bit a, input bit c,
                        input int ea, input string req);
        rst = r; stall = s; adv = a; sel = c; ext_addr = ea[AW-1:0];
        @(posedge clk);
        model_edge(r, s, a, c, ea);
        @(negedge clk);
        compare(req);
    endtask

    task automatic expect_addr(input int exp, input string req);
        checks++;
        if (int'(acc_addr) != exp || !acc_valid) begin
            errors++;
            $display("FAIL %s directed acc_addr actual=%h/%0d expected=%h/1",
                     req, acc_addr, acc_valid, exp[AW-1:0]);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        order_ilv = 1'b0;
        step(1, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 1, 17'h1234, "R1");
        step(0, 0, 1, 0, 0, "R7");

        // R2 load, R3 linear advances with noisy ext_addr (R6) and sel (R9)
        step(0, 0, 0, 1, 17'h0A5B5, "R2");
        expect_addr(17'h0A5B5, "R2");
        step(0, 0, 1, 0, 17'h1FFFF, "R3");
        expect_addr(17'h0A5B6, "R3");
        step(0, 0, 1, 1, 17'h00000, "R6");
        expect_addr(17'h0A5B7, "R6");
        step(0, 0, 1, 0, 17'h12345, "R9");
        expect_addr(17'h0A5B4, "R9");
        step(0, 0, 1, 1, 17'h0F0F0, "R5");
        expect_addr(17'h0A5B5, "R5");

        // R8: stall mid burst with a would-be load
        step(0, 0, 1, 1, 0, "R3");
        step(0, 1, 0, 1, 17'h11111, "R8");
        step(0, 1, 1, 0, 17'h02222, "R8");
        step(0, 0, 1, 1, 0, "R8");
        expect_addr(17'h0A5B7, "R8");

        // R7: deselect ends the burst
        step(0, 0, 0, 0, 17'h03333, "R7");
        step(0, 0, 1, 1, 0, "R7");
        step(0, 0, 1, 0, 0, "R7");

        // linear from low bits 3
        step(0, 0, 0, 1, 17'h1C003, "R2");
        for (int i = 0; i < 5; i++) step(0, 0, 1, i[0], 17'h05555, "R3");

        // interleaved mode (static, changed only under reset)
        order_ilv = 1'b1;
        step(1, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 1, 17'h07771, "R2");
        step(0, 0, 1, 1, 0, "R4");
        expect_addr(17'h07770, "R4");
        step(0, 0, 1, 0, 17'h1ABCD, "R4");
        expect_addr(17'h07773, "R4");
        step(0, 0, 1, 1, 0, "R4");
        expect_addr(17'h07772, "R4");
        step(0, 0, 1, 1, 0, "R5");
        expect_addr(17'h07771, "R5");
        step(0, 0, 0, 1, 17'h10002, "R2");
        step(0, 1, 1, 1, 0, "R8");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 17'h0FFFF, "R4");
        step(0, 0, 0, 0, 0, "R7");
        step(0, 0, 1, 1, 0, "R7");
        step(0, 0, 0, 1, 17'h00003, "R2");
        for (int i = 0; i < 6; i++) step(0, i == 2, 1, 1, 0, "R4");

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule